// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block carries out one stack-frame style block move between the general register file and word memory. A decoded two-word instruction names the first register, the last register, a base register and an 8-bit offset. On a save the block stores each register of the range in turn into successive memory words. On a restore it loads successive memory words back into the registers of the range. The base address is fixed once, when the instruction is accepted. After that there is one memory access per cycle in which the memory accepts it.

The register file and the memory both sit outside the block. The register file is read through a combinational address/data pair and written through a one-cycle write strobe. The memory port is a valid/ready interface. `mem_req` is the valid. An access completes on a cycle in which both `mem_req` and `mem_rdy` are high. While `mem_rdy` is low the block holds the address, the direction and the write data, and it does not move on. Read data on `mem_rdata` is combinational and is taken in the completing cycle. `start`, `busy` and `done` are plain control pins.

Top module: `regblk_sequencer`

## Requirements
- R1: A `start` while idle is accepted only when `instr_hi[15:12]` = 0xE and `instr_hi[7:0]` is 0x0B (save) or 0x0C (restore). The fields are: first register `instr_hi[11:8]`, last register `instr_lo[15:12]`, base register `instr_lo[11:8]`, offset `instr_lo[7:0]`. Any other code is ignored, so no access follows and `busy` stays low.
- R2: The base address is the base register's value plus the zero-extended offset, modulo 2^16. It is taken from the register file in the cycle `start` is accepted, and base register 0 counts as 0.
- R3: On a save, transfer k (counting from 0) drives `mem_we`=1, address base+k modulo 2^16, and the value of register (first+k) mod 16 on `mem_wdata`.
- R4: On a restore, transfer k drives `mem_we`=0 and address base+k. When `mem_rdy` is high it pulses `rf_we` with `rf_waddr` = (first+k) mod 16 and `rf_wdata` = `mem_rdata`.
- R5: Register 0 reads as 0. A save of register 0 writes 0, whatever the register file returns, and a restore into register 0 raises no `rf_we`.
- R6: The register index wraps from 15 to 0. A transfer moves ((last-first) mod 16)+1 registers, so one register when first equals last.
- R7: While `mem_rdy` is low, `mem_req` stays high and the address, direction and write data stay stable. No register write happens and the transfer does not advance.
- R8: The first access is presented in the cycle after `start` is accepted. After that, each cycle with `mem_rdy` high completes one transfer.
- R9: `done` is high for exactly the one cycle after the final transfer completes. `busy` is high from the cycle after acceptance up to and including the final transfer.
- R10: A `start` while `busy` is high is ignored. The running sequence keeps its addresses, registers and length.
- R11: A restore that overwrites the base register does not change the addresses of later transfers.
- R12: After reset the block is idle, with `busy`, `done`, `mem_req` and `rf_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin the instruction on the instruction words |
| instr_hi | input | 16 | First instruction word: opcode, first register, secondary code |
| instr_lo | input | 16 | Second instruction word: last register, base register, offset |
| busy | output | 1 | A transfer sequence is running |
| done | output | 1 | One-cycle pulse after the final transfer |
| rf_raddr | output | 4 | Register file read index (base register when idle, current register when busy) |
| rf_rdata | input | 16 | Register file read data for `rf_raddr` |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory access valid |
| mem_rdy | input | 1 | Memory ready; the access completes when valid and ready are both high |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data, combinational on `mem_addr` |

## Verification
The bench drives `start` half a period before the accepting edge. It expects the first access to appear in the very next cycle and one new access per edge at which `mem_rdy` was high. It expects `done` in the cycle right after the final completing edge, and low again one cycle later. Every access is sampled just after the falling edge, once `mem_rdy` for that cycle has settled. That is before the rising edge at which the access completes, so each sample sees the address, data and strobes of exactly one transfer. Register contents written by a restore are compared after `done`, across the whole register file.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned DISP_W = 8;
  localparam logic [3:0]  OP_EXT     = 4'hE;
  localparam logic [7:0]  SUB_SAVE   = 8'h0B;
  localparam logic [7:0]  SUB_RESTOR = 8'h0C;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  typedef struct packed {
    logic              is_save;
    logic [IDX_W-1:0]  first;
    logic [IDX_W-1:0]  last;
    logic [IDX_W-1:0]  base;
    logic [DISP_W-1:0] disp;
  } blk_cmd_t;
endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
  import regblk_pkg::*;
(
  input  logic [15:0] instr_hi,
  input  logic [15:0] instr_lo,
  output logic        cmd_ok,
  output blk_cmd_t    cmd
);
  logic is_sv, is_rs;

  always_comb begin
    is_sv       = (instr_hi[15:12] == OP_EXT) && (instr_hi[7:0] == SUB_SAVE);
    is_rs       = (instr_hi[15:12] == OP_EXT) && (instr_hi[7:0] == SUB_RESTOR);
    cmd_ok      = is_sv || is_rs;
    cmd.is_save = is_sv;
    cmd.first   = instr_hi[11:8];
    cmd.last    = instr_lo[15:12];
    cmd.base    = instr_lo[11:8];
    cmd.disp    = instr_lo[7:0];
  end
endmodule

// File: rtl/regblk_ctrl.sv
module regblk_ctrl
  import regblk_pkg::*;
#(
  parameter int unsigned AW = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_ok,
  input  logic              cmd_save,
  input  logic [IDX_W-1:0]  cmd_first,
  input  logic [IDX_W-1:0]  cmd_last,
  input  logic [DISP_W-1:0] cmd_disp,
  input  logic [AW-1:0]     base_val,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              done,
  output logic              save_mode,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [AW-1:0]     cur_addr
);
  seq_state_t       state;
  logic [IDX_W-1:0] last_idx;
  logic             final_step;

  assign busy       = (state == ST_RUN);
  assign final_step = busy && mem_rdy && (cur_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      save_mode <= 1'b0;
      cur_idx   <= '0;
      last_idx  <= '0;
      cur_addr  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start && cmd_ok) begin
          state     <= ST_RUN;
          save_mode <= cmd_save;
          cur_idx   <= cmd_first;
          last_idx  <= cmd_last;
          cur_addr  <= base_val + AW'(cmd_disp);
        end
        ST_RUN: if (mem_rdy) begin
          if (cur_idx == last_idx) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cur_idx  <= cur_idx + 1'b1;
            cur_addr <= cur_addr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    final_step |=> (done && !busy)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rdy && !final_step) |=> (busy && cur_addr == $past(cur_addr) + 1'b1)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rdy) |=> (busy && $stable(cur_addr) && $stable(cur_idx) && $stable(save_mode))); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !final_step) |=> (busy && $stable(last_idx) && $stable(save_mode))); // R10
endmodule

// File: rtl/regblk_xfer_path.sv
module regblk_xfer_path
  import regblk_pkg::*;
#(
  parameter int unsigned DW = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             save_mode,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [DW-1:0]    rf_rdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rdy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata
);
  logic idx_zero;

  always_comb begin
    idx_zero  = (cur_idx == '0);
    mem_req   = busy;
    mem_we    = busy && save_mode;
    mem_wdata = idx_zero ? '0 : rf_rdata;
    rf_we     = busy && !save_mode && mem_rdy && !idx_zero;
    rf_waddr  = cur_idx;
    rf_wdata  = mem_rdata;
  end

  AST_RF_WE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && !mem_we && mem_rdy)); // R4
  AST_NO_RF_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !rf_we); // R12
endmodule

// File: rtl/regblk_sequencer.sv
module regblk_sequencer
  import regblk_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr_hi,
  input  logic [15:0]   instr_lo,
  output logic          busy,
  output logic          done,
  output logic [3:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  input  logic          mem_rdy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  blk_cmd_t         cmd;
  logic             cmd_ok;
  logic             save_mode;
  logic [IDX_W-1:0] cur_idx;
  logic [AW-1:0]    base_val;

  regblk_decode u_dec (
    .instr_hi (instr_hi),
    .instr_lo (instr_lo),
    .cmd_ok   (cmd_ok),
    .cmd      (cmd)
  );

  assign rf_raddr = busy ? cur_idx : cmd.base;
  assign base_val = (cmd.base == '0) ? '0 : AW'(rf_rdata);

  regblk_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_ok    (cmd_ok),
    .cmd_save  (cmd.is_save),
    .cmd_first (cmd.first),
    .cmd_last  (cmd.last),
    .cmd_disp  (cmd.disp),
    .base_val  (base_val),
    .mem_rdy   (mem_rdy),
    .busy      (busy),
    .done      (done),
    .save_mode (save_mode),
    .cur_idx   (cur_idx),
    .cur_addr  (mem_addr)
  );

  regblk_xfer_path #(.DW(DW)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .save_mode (save_mode),
    .cur_idx   (cur_idx),
    .rf_rdata  (rf_rdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata)
  );

  AST_R0_STORES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && rf_raddr == 4'd0) |-> (mem_wdata == '0)); // R5
  AST_FIRST_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cmd_ok) |=> (mem_req && busy)); // R8
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cmd_ok) |=> !mem_req); // R1
endmodule

// File: tb/test_regblk_sequencer.sv
`timescale 1ns/100ps
module test_regblk_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr_hi = '0, instr_lo = '0;
  logic        busy, done, rf_we, mem_req, mem_we;
  logic        mem_rdy = 1'b1;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic        rf_init = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] rf [16];
  int          n_chk = 0, n_fail = 0;
  bit          fin = 1'b0;

  always #2 clk = ~clk;

  regblk_sequencer i_regblk_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_hi(instr_hi), .instr_lo(instr_lo),
    .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] rv(input int i, input logic [15:0] s);
    return (i == 0) ? 16'hDEAD : 16'(s + 16'(i) * 16'h1111);
  endfunction

  function automatic logic [15:0] mpat(input logic [15:0] a);
    return a ^ 16'h5A3C ^ {a[7:0], a[15:8]};
  endfunction

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mpat(mem_addr);

  always @(posedge clk) begin
    if (rf_init) begin
      for (int i = 0; i < 16; i++) rf[i] <= rv(i, seed);
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input bit sv, input int d, input int e, input int f,
                        input logic [7:0] disp, input logic [15:0] sd,
                        input bit stall_on, input bit inject);
    int n, k;
    bit stalled;
    logic [15:0] eb;
    logic [15:0] expr [16];
    n  = ((e - d) & 15) + 1;
    @(negedge clk);
    seed = sd; rf_init = 1'b1;
    @(negedge clk);
    rf_init  = 1'b0;
    instr_hi = {4'hE, 4'(d), sv ? 8'h0B : 8'h0C};
    instr_lo = {4'(e), 4'(f), disp};
    start    = 1'b1;
    eb = (f == 0) ? 16'(disp) : 16'(rv(f, sd) + 16'(disp));       // R2
    for (int i = 0; i < 16; i++) expr[i] = rv(i, sd);
    k = 0; stalled = 1'b0;
    while (k < n) begin
      @(negedge clk);
      start = 1'b0;
      if (inject && k == 1) begin                                    // R10
        start = 1'b1; instr_hi = 16'hE50C; instr_lo = 16'h2177;
      end
      mem_rdy = !(stall_on && (k % 3 == 1) && !stalled);
      #0.5;
      chk(mem_req && busy, "R8", {mem_req, busy}, 2'b11);
      chk(mem_addr == 16'(eb + 16'(k)), "R2", mem_addr, 16'(eb + 16'(k)));   // R11 when base in range
      chk(mem_we == sv, "R3", mem_we, sv);
      if (sv) begin
        automatic int r = (d + k) & 15;
        automatic logic [15:0] w = (r == 0) ? 16'h0 : rv(r, sd);     // R5
        chk(mem_wdata == w, (r == 0) ? "R5" : "R3", mem_wdata, w);
      end else begin
        automatic int r = (d + k) & 15;
        automatic bit wexp = mem_rdy && (r != 0);
        chk(rf_we == wexp, mem_rdy ? "R5" : "R7", rf_we, wexp);
        if (wexp) begin
          chk(rf_waddr == 4'(r) && rf_wdata == mpat(mem_addr), "R4", {rf_waddr, rf_wdata}, {4'(r), mpat(mem_addr)});
          expr[r] = mpat(16'(eb + 16'(k)));
        end
      end
      if (!mem_rdy) stalled = 1'b1;                                  // R7 next sample repeats k
      else begin k++; stalled = 1'b0; end
    end
    @(negedge clk);
    start = 1'b0; mem_rdy = 1'b1;
    #0.5;
    chk(done && !busy && !mem_req, "R9", {done, busy, mem_req}, 3'b100);   // R6 length
    @(negedge clk);
    #0.5;
    chk(!done, "R9", done, 1'b0);
    if (!sv) for (int i = 0; i < 16; i++)
      chk(rf[i] == expr[i], "R6", rf[i], expr[i]);
  endtask

  task automatic bad_code(input logic [15:0] w1);
    @(negedge clk);
    instr_hi = w1; instr_lo = 16'h3412; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #0.5;
    chk(!busy && !mem_req, "R1", {busy, mem_req}, 2'b00);
  endtask

  initial begin
    #(4 * 150000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #9;
    #0.5;
    chk(!busy && !done && !mem_req && !rf_we, "R12", {busy, done, mem_req, rf_we}, 4'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(!busy && !done && !mem_req && !rf_we, "R12", {busy, done, mem_req, rf_we}, 4'b0);
    bad_code(16'hE30D);
    bad_code(16'hD30B);
    bad_code(16'hE31B);
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < 16; d++)
        for (int e = 0; e < 16; e++)
          run_op(op == 0, d, e, (d + e) & 15, 8'(d * 17 + e * 5),
                 (op == 0) ? 16'hFFF0 : 16'h7F00 + 16'(d),
                 ((d + e) % 4) == 0, (d ^ e) == 3);
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule